// File: doc/BRIEF.md
# Serial Zero-Free Brick Encoder

This block compacts one group of activation values into a zero-free brick. A group is a fixed number of neighbouring outputs (16 by default) that share their spatial position and follow each other along the feature axis. The encoder keeps only the values that carry information and stores each one together with a small tag. The tag gives the lane index the value had in the dense group, so that a later consumer can pick the matching weight directly. The brick keeps the width of the dense group, so it can be stored at the address the uncompressed group would have had.

The encoder works serially. A start request loads the group into an input register bank and clears the output bank. For the next LANES cycles the block looks at one lane per cycle in ascending index order. A lane that survives is appended to the next free output slot together with its index. When every lane has been looked at, the block raises a one-cycle done strobe and presents the brick as a single wide word, along with the number of valid slots. An optional pruning mode also drops values whose magnitude is below a per-layer threshold. The threshold and the mode are captured with the group, so changing them during a conversion has no effect.

Top module: `zf_brick_encoder`

## Requirements
- R1: After reset, busy_o and done_o are low, brick_cnt_o is 0 and every value and offset slot of the brick is 0.
- R2: When start_i is high with busy_o low, the group is accepted on that clock edge and busy_o is high from the next cycle on. done_o rises after the LANES-th following edge (latency LANES+1 cycles from the accepting edge) and lasts one cycle, with busy_o still high. busy_o is low in the cycle after done_o.
- R3: Each surviving lane is placed in the lowest free slot, in ascending order of its lane index. Lane k of group_i is bits [k*DATA_W +: DATA_W], and slot j of the brick is bits [j*DATA_W +: DATA_W] of brick_val_o. The slot's offset, bits [j*4 +: 4] of brick_ofs_o (for 16 lanes), equals that lane index.
- R4: brick_cnt_o equals the number of surviving lanes and is at most LANES.
- R5: Every slot at or above brick_cnt_o holds value 0 and offset 0.
- R6: With prune_en_i high, a lane survives only if it is non-zero and its magnitude is at least thresh_i. Values are signed two's complement and thresh_i is unsigned, so the most negative value has magnitude 2^(DATA_W-1). A threshold of 0 drops only exact zeros.
- R7: With prune_en_i low, thresh_i has no effect and exactly the non-zero lanes survive.
- R8: A start_i request while busy_o is high is ignored. group_i, prune_en_i and thresh_i are sampled only on the accepting edge, so changing them during a conversion does not alter the brick.
- R9: While the block is idle and no start is accepted, the brick outputs and brick_cnt_o hold their last values whatever group_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to convert the group on group_i |
| group_i | input | LANES*DATA_W | Dense group, lane k at bits [k*DATA_W +: DATA_W] |
| prune_en_i | input | 1 | Enables threshold pruning for this group |
| thresh_i | input | DATA_W | Unsigned magnitude threshold |
| busy_o | output | 1 | Conversion in progress, including the done cycle |
| done_o | output | 1 | One-cycle strobe, brick complete |
| brick_val_o | output | LANES*DATA_W | Compacted values, slot j at bits [j*DATA_W +: DATA_W] |
| brick_ofs_o | output | LANES*$clog2(LANES) | Original lane index of each slot |
| brick_cnt_o | output | $clog2(LANES+1) | Number of valid slots |

## Verification
An all-zero group and a fully dense group test the two extremes of the count and of the padding. A single non-zero value walked through every lane shows whether offsets follow the lane index and whether the last lane is examined at all. Signed ramps swept against a range of thresholds, with the most negative value included, separate a correct magnitude compare from an off-by-one or sign error, and the same group with pruning off shows that the threshold is ignored. A run whose inputs and start are disturbed during the scan tests the capture at acceptance, and several hundred pseudo-random sparse groups with mixed modes are compared slot by slot against an arithmetic model.

// File: rtl/zf_pkg.sv
package zf_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SCAN = 2'd1,
        PH_DONE = 2'd2
    } zf_phase_e;

endpackage

// File: rtl/zf_keep_test.sv
module zf_keep_test #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] value_i,
    input  logic              prune_en_i,
    input  logic [DATA_W-1:0] thresh_i,
    output logic              keep_o
);
    localparam int MAG_W = DATA_W + 1;

    logic [MAG_W-1:0] mag;
    logic             nonzero;

    always_comb begin
        if (value_i[DATA_W-1]) begin
            mag = {1'b0, ~value_i} + MAG_W'(1);
        end else begin
            mag = {1'b0, value_i};
        end
        nonzero = |value_i;
        keep_o  = nonzero && (!prune_en_i || (mag >= {1'b0, thresh_i}));
    end

endmodule

// File: rtl/zf_in_buf.sv
module zf_in_buf #(
    parameter int LANES  = 16,
    parameter int DATA_W = 16,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [LANES*DATA_W-1:0] group_i,
    input  logic [OFS_W-1:0]        sel_i,
    output logic [DATA_W-1:0]       value_o
);
    typedef struct packed {
        logic [LANES-1:0][DATA_W-1:0] lane;
    } inbuf_t;

    inbuf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (load_i) begin
            buf_d.lane = group_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign value_o = buf_q.lane[sel_i];

endmodule

// File: rtl/zf_scan_ctrl.sv
module zf_scan_ctrl
    import zf_pkg::*;
#(
    parameter int LANES = 16,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             accept_o,
    output logic             scan_o,
    output logic             done_o,
    output logic             busy_o,
    output logic [OFS_W-1:0] idx_o
);
    localparam logic [OFS_W-1:0] LAST_IDX = OFS_W'(LANES - 1);

    typedef struct packed {
        zf_phase_e        phase;
        logic [OFS_W-1:0] idx;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  accept;

    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    accept     = 1'b1;
                    st_d.phase = PH_SCAN;
                    st_d.idx   = '0;
                end
            end
            PH_SCAN: begin
                st_d.idx = st_q.idx + OFS_W'(1);
                if (st_q.idx == LAST_IDX) begin
                    st_d.phase = PH_DONE;
                end
            end
            PH_DONE: begin
                st_d.phase = PH_IDLE;
                st_d.idx   = '0;
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.idx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign accept_o = accept;
    assign scan_o   = (st_q.phase == PH_SCAN);
    assign done_o   = (st_q.phase == PH_DONE);
    assign busy_o   = (st_q.phase != PH_IDLE);
    assign idx_o    = st_q.idx;

endmodule

// File: rtl/zf_pack_buf.sv
module zf_pack_buf #(
    parameter int LANES  = 16,
    parameter int DATA_W = 16,
    localparam int OFS_W = $clog2(LANES),
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    wr_en_i,
    input  logic [DATA_W-1:0]       wr_val_i,
    input  logic [OFS_W-1:0]        wr_ofs_i,
    output logic [LANES*DATA_W-1:0] val_o,
    output logic [LANES*OFS_W-1:0]  ofs_o,
    output logic [CNT_W-1:0]        cnt_o
);
    typedef struct packed {
        logic [LANES-1:0][DATA_W-1:0] val;
        logic [LANES-1:0][OFS_W-1:0]  ofs;
        logic [CNT_W-1:0]             cnt;
    } pack_t;

    pack_t pk_d, pk_q;
    logic [OFS_W-1:0] wr_ptr;

    always_comb begin
        pk_d   = pk_q;
        wr_ptr = pk_q.cnt[OFS_W-1:0];
        if (clear_i) begin
            pk_d = '0;
        end else if (wr_en_i && (pk_q.cnt < CNT_W'(LANES))) begin
            pk_d.val[wr_ptr] = wr_val_i;
            pk_d.ofs[wr_ptr] = wr_ofs_i;
            pk_d.cnt         = pk_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pk_q <= '0;
        end else begin
            pk_q <= pk_d;
        end
    end

    assign val_o = pk_q.val;
    assign ofs_o = pk_q.ofs;
    assign cnt_o = pk_q.cnt;

endmodule

// File: rtl/zf_brick_encoder.sv
module zf_brick_encoder #(
    parameter int LANES  = 16,
    parameter int DATA_W = 16,
    localparam int OFS_W = $clog2(LANES),
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [LANES*DATA_W-1:0] group_i,
    input  logic                    prune_en_i,
    input  logic [DATA_W-1:0]       thresh_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [LANES*DATA_W-1:0] brick_val_o,
    output logic [LANES*OFS_W-1:0]  brick_ofs_o,
    output logic [CNT_W-1:0]        brick_cnt_o
);
    typedef struct packed {
        logic              prune;
        logic [DATA_W-1:0] thresh;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic              accept;
    logic              scanning;
    logic [OFS_W-1:0]  scan_idx;
    logic [DATA_W-1:0] cur_val;
    logic              cur_keep;

    zf_scan_ctrl #(
        .LANES(LANES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .scan_o   (scanning),
        .done_o   (done_o),
        .busy_o   (busy_o),
        .idx_o    (scan_idx)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (accept) begin
            cfg_d.prune  = prune_en_i;
            cfg_d.thresh = thresh_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    zf_in_buf #(
        .LANES (LANES),
        .DATA_W(DATA_W)
    ) u_inbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .group_i (group_i),
        .sel_i   (scan_idx),
        .value_o (cur_val)
    );

    zf_keep_test #(
        .DATA_W(DATA_W)
    ) u_keep (
        .value_i    (cur_val),
        .prune_en_i (cfg_q.prune),
        .thresh_i   (cfg_q.thresh),
        .keep_o     (cur_keep)
    );

    zf_pack_buf #(
        .LANES (LANES),
        .DATA_W(DATA_W)
    ) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .wr_en_i  (scanning && cur_keep),
        .wr_val_i (cur_val),
        .wr_ofs_i (scan_idx),
        .val_o    (brick_val_o),
        .ofs_o    (brick_ofs_o),
        .cnt_o    (brick_cnt_o)
    );

endmodule

// File: rtl/zf_brick_encoder_chk.sv
module zf_brick_encoder_chk #(
    parameter int LANES  = 16,
    parameter int DATA_W = 16,
    localparam int OFS_W = $clog2(LANES),
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_i,
    input logic [LANES*DATA_W-1:0] group_i,
    input logic                    prune_en_i,
    input logic [DATA_W-1:0]       thresh_i,
    input logic                    busy_o,
    input logic                    done_o,
    input logic [LANES*DATA_W-1:0] brick_val_o,
    input logic [LANES*OFS_W-1:0]  brick_ofs_o,
    input logic [CNT_W-1:0]        brick_cnt_o
);
    int run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= 0;
        end else if (start_i && !busy_o) begin
            run_len <= 0;
        end else if (busy_o && !done_o) begin
            run_len <= run_len + 1;
        end
    end

    // R2: accepted start makes the block busy
    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R2: done lasts one cycle and the block is idle afterwards
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R2: done only while busy
    a_r2_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R2: scan length counted in the checker
    a_r2_scan_length: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_len == LANES));

    // R4: count never exceeds the brick width
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(brick_cnt_o) <= LANES);

    // R9: idle without start keeps the brick unchanged
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(brick_cnt_o) && $stable(brick_val_o)
                                   && $stable(brick_ofs_o)));

    for (genvar i = 0; i < LANES; i++) begin : g_slot
        // R5: slots past the count are zero padded
        a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (done_o && (int'(brick_cnt_o) <= i)) |->
            ((brick_val_o[i*DATA_W +: DATA_W] == '0) && (brick_ofs_o[i*OFS_W +: OFS_W] == '0)));
        // R3: valid slots hold non-zero values
        a_r3_slot_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
            (done_o && (int'(brick_cnt_o) > i)) |->
            (brick_val_o[i*DATA_W +: DATA_W] != '0));
        if (i < LANES - 1) begin : g_ord
            // R3: offsets rise strictly across valid slots
            a_r3_ofs_order: assert property (@(posedge clk) disable iff (!rst_n)
                (done_o && (int'(brick_cnt_o) > i + 1)) |->
                (brick_ofs_o[i*OFS_W +: OFS_W] < brick_ofs_o[(i+1)*OFS_W +: OFS_W]));
        end
    end

endmodule

bind zf_brick_encoder zf_brick_encoder_chk #(
    .LANES (LANES),
    .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/zf_brick_encoder_tb.sv
module zf_brick_encoder_tb;
    localparam int LANES    = 16;
    localparam int DATA_W   = 16;
    localparam int OFS_W    = $clog2(LANES);
    localparam int CNT_W    = $clog2(LANES + 1);
    localparam int GW       = LANES * DATA_W;
    localparam time CLK_PER = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [GW-1:0]     group_i = '0;
    logic              prune_en_i = 1'b0;
    logic [DATA_W-1:0] thresh_i = '0;
    logic              busy_o, done_o;
    logic [GW-1:0]     brick_val_o;
    logic [LANES*OFS_W-1:0] brick_ofs_o;
    logic [CNT_W-1:0]  brick_cnt_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    logic [GW-1:0]          exp_val;
    logic [LANES*OFS_W-1:0] exp_ofs;
    int                     exp_cnt;

    always #(CLK_PER/2) clk = ~clk;

    zf_brick_encoder #(.LANES(LANES), .DATA_W(DATA_W)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] rnd();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    task automatic model(input logic [GW-1:0] g, input logic pe, input logic [DATA_W-1:0] th);
        exp_val = '0;
        exp_ofs = '0;
        exp_cnt = 0;
        for (int k = 0; k < LANES; k++) begin
            int v;
            int mag;
            v   = int'($signed(g[k*DATA_W +: DATA_W]));
            mag = (v < 0) ? -v : v;
            if (v != 0 && (!pe || mag >= int'(th))) begin
                exp_val[exp_cnt*DATA_W +: DATA_W] = g[k*DATA_W +: DATA_W];
                exp_ofs[exp_cnt*OFS_W +: OFS_W]   = OFS_W'(k);
                exp_cnt++;
            end
        end
    endtask

    task automatic run_group(input logic [GW-1:0] g, input logic pe,
                             input logic [DATA_W-1:0] th, input bit disturb,
                             input string tag);
        int lat;
        model(g, pe, th);
        @(negedge clk);
        group_i    = g;
        prune_en_i = pe;
        thresh_i   = th;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        chk(busy_o == 1'b1, "R2", {tag, " busy after start"}, busy_o, 1);
        while (!done_o && lat < 64) begin
            if (disturb) begin
                // R8: these changes must not reach the brick
                group_i    = ~group_i;
                prune_en_i = ~prune_en_i;
                thresh_i   = thresh_i ^ 16'h00F3;
                start_i    = 1'b1;
            end
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        chk(lat == LANES + 1, "R2", {tag, " done latency"}, lat, LANES + 1);
        chk(busy_o == 1'b1, "R2", {tag, " busy during done"}, busy_o, 1);
        chk(int'(brick_cnt_o) == exp_cnt, disturb ? "R8" : "R4", {tag, " count"},
            brick_cnt_o, exp_cnt);
        for (int j = 0; j < LANES; j++) begin
            longint act = {brick_val_o[j*DATA_W +: DATA_W], brick_ofs_o[j*OFS_W +: OFS_W]};
            longint ex  = {exp_val[j*DATA_W +: DATA_W], exp_ofs[j*OFS_W +: OFS_W]};
            chk(act == ex, (j < exp_cnt) ? (disturb ? "R8" : "R3") : "R5",
                $sformatf("%s slot %0d {val,ofs}", tag, j), act, ex);
        end
        @(negedge clk);
        chk(!done_o && !busy_o, "R2", {tag, " idle after done"}, {done_o, busy_o}, 0);
        // R9: idle inputs wiggle, brick holds
        group_i    = {rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd(), rnd()};
        thresh_i   = rnd();
        prune_en_i = ~prune_en_i;
        repeat (2) @(negedge clk);
        chk((brick_val_o == exp_val) && (brick_ofs_o == exp_ofs) &&
            (int'(brick_cnt_o) == exp_cnt), "R9", {tag, " hold while idle"},
            brick_cnt_o, exp_cnt);
    endtask

    function automatic logic [GW-1:0] ramp(input int base);
        logic [GW-1:0] g = '0;
        for (int k = 0; k < LANES; k++) begin
            g[k*DATA_W +: DATA_W] = DATA_W'(base + k);
        end
        return g;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [GW-1:0] g;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy_o && !done_o, "R1", "busy/done in reset", {busy_o, done_o}, 0);
        chk(brick_cnt_o == '0 && brick_val_o == '0 && brick_ofs_o == '0, "R1",
            "brick cleared in reset", brick_cnt_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && brick_cnt_o == '0, "R1", "state after reset",
            {busy_o, done_o}, 0);

        // R4/R5 extremes
        run_group('0, 1'b0, '0, 1'b0, "all zero");
        run_group(ramp(1), 1'b0, '0, 1'b0, "all dense");

        // R3: short example 1,0,0,3
        g = '0;
        g[0*DATA_W +: DATA_W] = 16'd1;
        g[3*DATA_W +: DATA_W] = 16'd3;
        run_group(g, 1'b0, '0, 1'b0, "example");

        // R3: walking single value
        for (int p = 0; p < LANES; p++) begin
            g = '0;
            g[p*DATA_W +: DATA_W] = DATA_W'(-(p + 2));
            run_group(g, 1'b0, '0, 1'b0, $sformatf("walk %0d", p));
        end

        // R6: threshold sweep over a signed ramp
        for (int t = 0; t < 10; t++) begin
            run_group(ramp(-8), 1'b1, DATA_W'(t), 1'b0, $sformatf("prune thr %0d", t));
        end

        // R6: most negative value
        g = ramp(-8);
        g[5*DATA_W +: DATA_W] = 16'h8000;
        run_group(g, 1'b1, 16'h8000, 1'b0, "min value kept");
        run_group(g, 1'b1, 16'hFFFF, 1'b0, "min value dropped");

        // R7: threshold ignored when pruning is off
        run_group(ramp(-8), 1'b0, 16'd100, 1'b0, "prune off");

        // R8: disturbed inputs and repeated start during scan
        run_group(ramp(-5), 1'b1, 16'd3, 1'b1, "disturb prune");
        run_group(g, 1'b0, 16'd7, 1'b1, "disturb plain");

        // pseudo-random sparse groups
        for (int r = 0; r < 300; r++) begin
            logic [31:0] s;
            logic [31:0] cfg;
            for (int k = 0; k < LANES; k++) begin
                s = rnd();
                g[k*DATA_W +: DATA_W] = s[0] ? '0 : DATA_W'($signed(s[13:8]));
            end
            cfg = rnd();
            run_group(g, cfg[0], DATA_W'(cfg[7:4]), cfg[8] & cfg[9], $sformatf("rand %0d", r));
        end

        finish_run();
    end

endmodule